// File: doc/BRIEF.md
# Serial ADC Sample Sequencer

This block takes one complete sample from a low-power 12-bit serial converter. A single-cycle start pulse begins the sequence. If power control is enabled, the block first releases the converter's shutdown line and waits for it to wake.

It then pulls chip-select low with the serial clock parked. It holds that state long enough for the conversion to finish. Next it clocks in a 16-bit frame, most significant bit first. Finally it releases chip-select, extracts the 12-bit result and puts the converter back into shutdown.

Each delay is given in nanoseconds and converted to whole system-clock cycles, rounding up, from a clock-frequency parameter. The serial clock is a divided copy of the system clock. Around the block, a start/busy/done handshake carries the request and the result.

Top module: `adc_sample_ctrl`

## Requirements
- R1: With power control active for a sample (SHDN_CTRL=1 and pwr_ctl_en_i high when start is accepted), shdn_o goes low one cycle after the accepting edge. cs_no then stays high for WAKE_CYC = ceil(WAKE_NS*CLK_HZ/1e9) cycles.
- R2: After the wake interval, or at once when power control is off, cs_no goes low and sclk_o stays low for CONV_CYC = ceil(CONV_NS*CLK_HZ/1e9) cycles.
- R3: The read phase produces exactly 16 sclk_o pulses, each SCLK_HALF cycles high and SCLK_HALF cycles low, with sclk_o idling low. miso_i is sampled on the system edge where sclk_o rises, and the first bit taken is frame bit 15.
- R4: result_o equals frame bits 14:3, that is (frame >> 3) & 0xFFF. It changes only together with done_o and holds until the next done_o.
- R5: When power control is active for a sample, shdn_o returns high on the same edge that releases cs_no.
- R6: When pwr_ctl_en_i is low at the accepted start, the wake interval is skipped and shdn_o is driven low and stays low through the end of the sample. With SHDN_CTRL=0, shdn_o is tied low.
- R7: In reset: shdn_o is high (when SHDN_CTRL=1), cs_no is high, and sclk_o, busy_o, done_o and result_o are 0.
- R8: busy_o is high from the cycle after an accepted start until the block is idle again, and a start seen while busy is ignored. done_o is a single-cycle pulse.
- R9: cs_no rises on the falling sclk_o edge that follows the 16th rising edge. busy_o stays high for a further 2*SCLK_HALF cycles so that cs_no is held high for at least one serial clock period before the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| pwr_ctl_en_i | input | 1 | Use shutdown sequencing for this sample |
| busy_o | output | 1 | Sample sequence in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 12 | Extracted conversion result |
| cs_no | output | 1 | Converter chip-select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| miso_i | input | 1 | Serial data from converter |
| shdn_o | output | 1 | Converter shutdown, active high |

## Verification
The hardest case to reach from the ports is a start request that arrives on the very first edge at which the block is idle again, right after the hold-off that follows chip-select release. It matters alongside starts that arrive in the middle of a conversion. The bench reaches the first case by holding start_i high across two complete samples, and the second by pulsing start_i during both the conversion and the read phases. Its timeline model marks which edges may accept a start, so a restart that comes one cycle early or late shows up as a mismatch on cs_no or busy_o. Frames with ones only outside bits 14:3, and with all ones, test the field extraction at its edges.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_CONV,
    ST_SHIFT,
    ST_GAP
  } rd_state_e;

  // ns -> whole clock cycles, rounded up, at least one
  function automatic int cycles_for_ns(longint ns, longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TIMER_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic sclk_o,
  output logic rise_o
);

  logic sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sclk_q <= 1'b0;
    else if (toggle_i) sclk_q <= ~sclk_q;
  end

  assign sclk_o = sclk_q;
  assign rise_o = toggle_i & ~sclk_q;

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FRAME_W = 16,
  parameter int RES_W   = 12,
  parameter int RES_LSB = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic             miso_i,
  input  logic             capture_i,
  output logic             full_o,
  output logic [RES_W-1:0] result_o
);

  localparam int CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [CW-1:0]      cnt_q;
  logic [RES_W-1:0]   res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (sample_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], miso_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (capture_i) res_q <= frame_q[RES_LSB+RES_W-1:RES_LSB];
  end

  assign full_o   = (cnt_q == CW'(FRAME_W));
  assign result_o = res_q;

  AST_NO_EXTRA_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (cnt_q < CW'(FRAME_W))); // R3
  AST_CAPTURE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> full_o); // R3

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
  import adc_rd_pkg::*;
#(
  parameter int       CLK_HZ    = 125_000_000,
  parameter int       WAKE_NS   = 4000,
  parameter int       CONV_NS   = 8000,
  parameter int       SCLK_HALF = 4,
  parameter bit       SHDN_CTRL = 1'b1,
  parameter int       FRAME_W   = 16,
  parameter int       RES_W     = 12,
  parameter int       RES_LSB   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pwr_ctl_en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             cs_no,
  output logic             sclk_o,
  input  logic             miso_i,
  output logic             shdn_o
);

  localparam int WAKE_CYC = cycles_for_ns(longint'(WAKE_NS), longint'(CLK_HZ));
  localparam int CONV_CYC = cycles_for_ns(longint'(CONV_NS), longint'(CLK_HZ));
  localparam int GAP_CYC  = 2 * SCLK_HALF;
  localparam int MAX_CYC  = max3(WAKE_CYC, CONV_CYC, GAP_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);

  rd_state_e     state_q, state_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          tgl, rise, clr, cap, accept, finish, full;
  logic          cs_q, done_q, pwr_q;
  logic          pwr_eff;

  assign pwr_eff = SHDN_CTRL & pwr_ctl_en_i;

  adc_rd_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni,
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  adc_rd_sclk u_sclk (
    .clk_i, .rst_ni,
    .toggle_i (tgl),
    .sclk_o   (sclk_o),
    .rise_o   (rise)
  );

  adc_rd_shift #(.FRAME_W(FRAME_W), .RES_W(RES_W), .RES_LSB(RES_LSB)) u_shift (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .sample_i  (rise),
    .miso_i    (miso_i),
    .capture_i (cap),
    .full_o    (full),
    .result_o  (result_o)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    tgl     = 1'b0;
    clr     = 1'b0;
    cap     = 1'b0;
    accept  = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        accept = 1'b1;
        t_load = 1'b1;
        if (pwr_eff) begin
          state_d = ST_WAKE;
          t_val   = TW'(WAKE_CYC - 1);
        end else begin
          state_d = ST_CONV;
          t_val   = TW'(CONV_CYC - 1);
        end
      end
      ST_WAKE: if (t_zero) begin
        state_d = ST_CONV;
        t_load  = 1'b1;
        t_val   = TW'(CONV_CYC - 1);
      end
      ST_CONV: if (t_zero) begin
        state_d = ST_SHIFT;
        t_load  = 1'b1;
        t_val   = TW'(SCLK_HALF - 1);
        clr     = 1'b1;
      end
      ST_SHIFT: if (t_zero) begin
        tgl    = 1'b1;
        t_load = 1'b1;
        t_val  = TW'(SCLK_HALF - 1);
        if (sclk_o && full) begin
          state_d = ST_GAP;
          t_val   = TW'(GAP_CYC - 1);
          cap     = 1'b1;
          finish  = 1'b1;
        end
      end
      ST_GAP: if (t_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      pwr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= !(state_d == ST_CONV || state_d == ST_SHIFT);
      done_q  <= finish;
      if (accept) pwr_q <= pwr_eff;
    end
  end

  generate
    if (SHDN_CTRL) begin : g_shdn
      logic shdn_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      shdn_q <= 1'b1;
        else if (accept)  shdn_q <= 1'b0;
        else if (finish)  shdn_q <= pwr_q;
      end
      assign shdn_o = shdn_q;
    end else begin : g_no_shdn
      assign shdn_o = 1'b0;
    end
  endgenerate

  assign cs_no  = cs_q;
  assign done_o = done_q;
  assign busy_o = (state_q != ST_IDLE);

  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R3
  AST_AWAKE_IN_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> (!shdn_o && cs_no)); // R1
  AST_AWAKE_WHILE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !shdn_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && busy_o)); // R9
  AST_SELECT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o); // R8
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o); // R4

endmodule

// File: tb/adc_sample_ctrl_test.sv
`timescale 1ns/1ps
module adc_sample_ctrl_test;

  localparam int HALF   = 4;
  localparam int T_WAKE = (4000 * 125 + 999) / 1000;
  localparam int T_CONV = (8000 * 125 + 999) / 1000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pwr = 1'b0, miso = 1'b0;
  logic busy, done, cs_n, sclk, shdn;
  logic [11:0] result;

  always #4 clk = ~clk;

  adc_sample_ctrl #(.CLK_HZ(125_000_000), .WAKE_NS(4000), .CONV_NS(8000),
                    .SCLK_HALF(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwr_ctl_en_i(pwr),
    .busy_o(busy), .done_o(done), .result_o(result), .cs_no(cs_n),
    .sclk_o(sclk), .miso_i(miso), .shdn_o(shdn)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_en = 1'b0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // timeline reference model
  int          m_n = 0;
  bit          m_pwr = 1'b0, m_shdn = 1'b1;
  logic [15:0] m_frame = '0, tb_frame = '0;
  logic [11:0] m_res = '0;

  function automatic int wake_len();
    return m_pwr ? T_WAKE : 0;
  endfunction
  function automatic int end_edge();
    return wake_len() + T_CONV + 1 + 32 * HALF;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=%0d expected<=150000", cyc);
      summary();
    end
    if (!rst_n) begin
      m_n = 0; m_res = '0; m_shdn = 1'b1;
    end else if (m_n == 0) begin
      if (start) begin
        m_n = 1; m_pwr = pwr; m_frame = tb_frame; m_shdn = 1'b0;
      end
    end else begin
      m_n++;
      if (m_n == end_edge()) begin
        m_res  = (m_frame >> 3) & 12'hFFF;
        m_shdn = m_pwr;
      end
      if (m_n == end_edge() + 2 * HALF) m_n = 0;
    end
  end

  // compare every clock, then drive MISO like the converter
  int rises = 0;
  bit prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      int s, e, w;
      bit ecs, esclk;
      w = wake_len(); s = w + T_CONV + 1; e = end_edge();
      ecs   = !(m_n != 0 && m_n >= w + 1 && m_n < e);
      esclk = (m_n != 0 && m_n >= s && m_n < e && (((m_n - s) / HALF) % 2 == 1));
      if (m_n != 0 && m_n <= w) check("R1 cs_no held during wake", cs_n, ecs);
      else if (m_n != 0 && m_n >= e) check("R9 cs_no released", cs_n, ecs);
      else check("R2 cs_no", cs_n, ecs);
      check("R3 sclk_o", sclk, esclk);
      check("R8 busy_o", busy, m_n != 0);
      check("R8 done_o", done, m_n != 0 && m_n == e);
      if (m_pwr) check("R5 shdn_o", shdn, m_shdn);
      else       check("R6 shdn_o", shdn, m_shdn);
      check("R4 result_o", result, m_res);
      if (done) check("R4 result_o at done", result, (tb_frame >> 3) & 12'hFFF);
    end
    if (cs_n) rises = 0;
    else if (sclk && !prev_sclk) rises++;
    prev_sclk = sclk;
    miso = (rises < 16) ? tb_frame[15 - rises] : 1'b0;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sample(logic [15:0] f, bit p, bit poke);
    tb_frame = f; pwr = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk); start = 1'b1;   // during wake/conversion
      @(negedge clk); start = 1'b0;
      while (cs_n) @(negedge clk);
      while (!sclk) @(negedge clk);
      start = 1'b1;                                // during read
      @(negedge clk); start = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 cs_no in reset", cs_n, 1);
    check("R7 sclk_o in reset", sclk, 0);
    check("R7 shdn_o in reset", shdn, 1);
    check("R7 busy_o in reset", busy, 0);
    check("R7 done_o in reset", done, 0);
    check("R7 result_o in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    check("R7 shdn_o after reset", shdn, 1);

    sample(16'hA5C3, 1'b1, 1'b1);
    sample(16'h7FF8, 1'b0, 1'b1);
    sample(16'h8007, 1'b1, 1'b0);
    sample(16'hFFFF, 1'b0, 1'b0);
    sample(16'h0000, 1'b1, 1'b0);

    // back-to-back: start held through two samples (R8, R9)
    begin
      int dn = 0;
      tb_frame = 16'h1234; pwr = 1'b1; start = 1'b1;
      while (dn < 2) begin
        @(negedge clk);
        if (done) dn++;
      end
      start = 1'b0;
      wait_idle();
    end
    check("R5 shdn_o back in shutdown", shdn, 1);
    check("R4 final result", result, (16'h1234 >> 3) & 12'hFFF);
    summary();
  end

endmodule